// File: doc/BRIEF.md
# Huffman Run-Length Scan Decompressor

This block sits between a tester channel and a scan chain and expands a serial stream of compressed test data back into scan-in bits. The tester sends one compressed bit per tester cycle. A parser walks a fixed prefix-free code tree and, when a codeword is complete, hands a run-length symbol to a pattern generator. The generator then shifts that pattern out on the faster chip clock, one bit per cycle. Patterns are grouped in blocks of four: a run of `L` zeros closed by a one, for `L` from 0 to 3, or four zeros with no closing one.

The whole block runs on a single chip clock. The slower tester rate is an integer ratio that a clock-enable divider derives. The pattern generator can still be draining a long pattern when the tester offers its next bit. A ready flag (`sync`) therefore tells the tester when a bit will be taken. While the flag is low, the tester holds its bit, and the parser ignores whatever is on the input.

Top module: `huff_test_decomp`

## Requirements
- R1: An active-high synchronous reset returns the parser to the tree root, even in the middle of a codeword. It empties the generator, so `scan_en` is 0 and `sync` is 1 in the first cycle after reset.
- R2: The one-bit codeword `1` produces four scan bits of value 0 with no closing 1.
- R3: A three-bit codeword `0 b1 b0` produces L zeros followed by a single 1, where L is the unsigned value of `b1 b0` (first bit received is the leftmost).
- R4: `scan_en` is high in exactly the cycles that carry a pattern bit, one bit per chip clock cycle. `scan_data` is 0 whenever `scan_en` is 0.
- R5: A compressed bit is taken only in a cycle where `tester_tick`, `sync` and `cmp_valid` are all 1. In any other cycle the value of `cmp_bit` has no effect on the scan output.
- R6: `sync` is 0 whenever the generator still holds two or more pattern bits. A new pattern is never loaded over unfinished bits.
- R7: `tester_tick` pulses once every `FREQ_RATIO` chip clock cycles, with the first pulse `FREQ_RATIO` cycles after reset.
- R8: Any sequence of codewords decompresses to the exact concatenation of the corresponding patterns. This includes sequences that end on the four-zero pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip test clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Tester presents a compressed bit |
| cmp_bit | input | 1 | Compressed data bit |
| sync | output | 1 | Decoder can accept a bit this cycle |
| tester_tick | output | 1 | Tester-rate enable, one pulse per FREQ_RATIO clocks |
| scan_data | output | 1 | Scan-in data bit |
| scan_en | output | 1 | Scan shift enable (qualifies scan_data) |

## Verification
The bench goes after a four-zero pattern loaded while the previous one is still draining. A design that let `sync` rise too early would overwrite bits and shorten the output stream. Streams that end on the four-zero pattern catch a generator that wrongly appends a closing 1 or drops trailing zeros. Garbage bits are shown whenever the handshake refuses, along with gaps in `cmp_valid`, to expose a parser that samples outside an accepted tick: it would decode a different codeword. A reset between the first and second bit of a three-bit codeword shows whether the parser really returns to the tree root.

// File: rtl/huff_decomp_pkg.sv
package huff_decomp_pkg;
   localparam int GROUP   = 4;
   localparam int NCODE   = GROUP + 1;
   localparam int MAXLEN  = 3;
   localparam int RUN_W   = $clog2(GROUP + 1);
   localparam int LEFT_W  = $clog2(GROUP + 2);
   localparam int DEPTH_W = $clog2(MAXLEN + 1);

   typedef logic [MAXLEN-1:0] cw_t;

   typedef struct packed {
      cw_t                bits;
      logic [DEPTH_W-1:0] len;
      logic [RUN_W-1:0]   run;
      logic               special;
   } code_ent_t;

   typedef struct packed {
      logic               valid;
      logic [RUN_W-1:0]   run;
      logic               special;
   } sym_t;

   // Entry 0: one-bit codeword for the all-zero group.
   // Entry k>0: leading 0 then run length k-1 in the remaining bits.
   function automatic code_ent_t code_entry(input int idx);
      code_ent_t e;
      if (idx == 0) begin
         e.bits    = cw_t'(1);
         e.len     = DEPTH_W'(1);
         e.run     = RUN_W'(GROUP);
         e.special = 1'b1;
      end else begin
         e.bits    = cw_t'(idx - 1);
         e.len     = DEPTH_W'(MAXLEN);
         e.run     = RUN_W'(idx - 1);
         e.special = 1'b0;
      end
      return e;
   endfunction
endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
   parameter int RATIO = 2
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   generate
      if (RATIO == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(RATIO);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (rst)
               div_q <= '0;
            else if (div_q == DW'(RATIO - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DW'(RATIO - 1));
      end
   endgenerate
endmodule

// File: rtl/huff_parser.sv
module huff_parser
   import huff_decomp_pkg::*;
(
   input  logic               clk,
   input  logic               rst,
   input  logic               take,
   input  logic               in_bit,
   output sym_t               sym,
   output logic [DEPTH_W-1:0] depth
);
   logic [MAXLEN-2:0]  sr_q;
   logic [MAXLEN-1:0]  wide;
   logic [DEPTH_W-1:0] nxt_len;
   logic [NCODE-1:0]   hit;

   assign wide    = {sr_q, in_bit};
   assign nxt_len = depth + 1'b1;

   generate
      for (genvar i = 0; i < NCODE; i++) begin : g_match
         localparam code_ent_t ENT = code_entry(i);
         assign hit[i] = (nxt_len == ENT.len) && (wide == ENT.bits);
      end
   endgenerate

   always_comb begin
      sym = '0;
      for (int i = 0; i < NCODE; i++) begin
         if (hit[i]) begin
            sym.run     = code_entry(i).run;
            sym.special = code_entry(i).special;
         end
      end
      sym.valid = take & (|hit);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         depth <= '0;
         sr_q  <= '0;
      end else if (take) begin
         if ((|hit) || (nxt_len == DEPTH_W'(MAXLEN))) begin
            depth <= '0;
            sr_q  <= '0;
         end else begin
            depth <= nxt_len;
            sr_q  <= wide[MAXLEN-2:0];
         end
      end
   end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
   import huff_decomp_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [RUN_W-1:0]  run,
   input  logic              special,
   output logic              scan_data,
   output logic              scan_en,
   output logic [LEFT_W-1:0] left
);
   logic spec_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         left   <= '0;
         spec_q <= 1'b0;
      end else if (load) begin
         left   <= special ? LEFT_W'(run) : LEFT_W'(run) + 1'b1;
         spec_q <= special;
      end else if (left != '0) begin
         left   <= left - 1'b1;
      end
   end

   assign scan_en   = (left != '0);
   assign scan_data = (left == LEFT_W'(1)) && !spec_q;
endmodule

// File: rtl/huff_test_decomp.sv
module huff_test_decomp
   import huff_decomp_pkg::*;
#(
   parameter int FREQ_RATIO = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cmp_valid,
   input  logic cmp_bit,
   output logic sync,
   output logic tester_tick,
   output logic scan_data,
   output logic scan_en
);
   if (FREQ_RATIO < 1) begin : g_bad_ratio
      $error("FREQ_RATIO must be at least 1");
   end
   if ((1 << (MAXLEN - 1)) < GROUP) begin : g_bad_code
      $error("code space too small for group size");
   end

   logic               take;
   sym_t               sym;
   logic [DEPTH_W-1:0] depth;
   logic [LEFT_W-1:0]  gen_left;

   tick_gen #(.RATIO(FREQ_RATIO)) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tester_tick)
   );

   assign sync = (gen_left <= LEFT_W'(1));
   assign take = tester_tick & sync & cmp_valid;

   huff_parser u_parse (
      .clk    (clk),
      .rst    (rst),
      .take   (take),
      .in_bit (cmp_bit),
      .sym    (sym),
      .depth  (depth)
   );

   pattern_gen u_gen (
      .clk       (clk),
      .rst       (rst),
      .load      (sym.valid),
      .run       (sym.run),
      .special   (sym.special),
      .scan_data (scan_data),
      .scan_en   (scan_en),
      .left      (gen_left)
   );
endmodule

// File: rtl/huff_decomp_checker.sv
module huff_decomp_checker
   import huff_decomp_pkg::*;
#(
   parameter int RATIO = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               tick,
   input logic               sync,
   input logic               cmp_valid,
   input logic               scan_en,
   input logic               scan_data,
   input logic [LEFT_W-1:0]  gen_left,
   input logic               gen_load,
   input logic               load_special,
   input logic [RUN_W-1:0]   load_run,
   input logic [DEPTH_W-1:0] depth
);
   logic        after_rst;
   logic [31:0] gap;

   always_ff @(posedge clk) after_rst <= rst;

   always_ff @(posedge clk) begin
      if (rst || tick) gap <= '0;
      else             gap <= gap + 1;
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      after_rst |-> (sync && !scan_en));

   assert_zero_group_R2: assert property (@(posedge clk) disable iff (rst)
      (gen_load && load_special) |=> (scan_en && !scan_data));

   assert_run_range_R3: assert property (@(posedge clk) disable iff (rst)
      (gen_load && !load_special) |-> (load_run < RUN_W'(GROUP)));

   assert_data_qualified_R4: assert property (@(posedge clk) disable iff (rst)
      scan_data |-> scan_en);

   assert_hold_parse_R5: assert property (@(posedge clk) disable iff (rst)
      !(tick && sync && cmp_valid) |=> $stable(depth));

   assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
      gen_load |-> (gen_left <= LEFT_W'(1)));

   assert_busy_stall_R6: assert property (@(posedge clk) disable iff (rst)
      (gen_left >= LEFT_W'(2)) |-> !sync);

   assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
      tick |-> (gap == 32'(RATIO - 1)));
endmodule

bind huff_test_decomp huff_decomp_checker #(.RATIO(FREQ_RATIO)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .tick         (tester_tick),
   .sync         (sync),
   .cmp_valid    (cmp_valid),
   .scan_en      (scan_en),
   .scan_data    (scan_data),
   .gen_left     (gen_left),
   .gen_load     (sym.valid),
   .load_special (sym.special),
   .load_run     (sym.run),
   .depth        (depth)
);

// File: tb/test_huff_test_decomp.sv
module test_huff_test_decomp;
   localparam int CLK_PERIOD = 10;
   localparam int RATIO      = 2;
   localparam int NVEC       = 6;
   localparam logic [23:0] VEC_SYMS [NVEC] = '{
      24'({3'd4, 3'd3, 3'd4, 3'd4, 3'd4, 3'd1, 3'd0}),
      24'({3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}),
      24'({3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4, 3'd4}),
      24'({3'd0, 3'd1, 3'd2, 3'd3}),
      24'({3'd2, 3'd4, 3'd3, 3'd4, 3'd0, 3'd4}),
      24'({3'd4})
   };
   localparam int VEC_CNT [NVEC] = '{7, 8, 8, 4, 6, 1};

   logic clk = 1'b0, rst = 1'b1, cmp_valid = 1'b0, cmp_bit = 1'b0;
   logic sync, tester_tick, scan_data, scan_en;

   int  n_tests = 0, n_fail = 0;
   bit  comp [0:1023];
   bit  expd [0:4095];
   bit  got  [0:4095];
   int  comp_n, exp_n, got_n;
   bit  collect = 1'b0;

   huff_test_decomp #(.FREQ_RATIO(RATIO)) i_huff_test_decomp (
      .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_bit(cmp_bit),
      .sync(sync), .tester_tick(tester_tick),
      .scan_data(scan_data), .scan_en(scan_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (collect && scan_en) begin
      got[got_n] = scan_data;
      got_n++;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic clear_stream();
      comp_n = 0; exp_n = 0; got_n = 0;
   endtask

   // software model of the code table
   task automatic add_sym(input int run);
      if (run == 4) begin
         comp[comp_n++] = 1'b1;
         for (int k = 0; k < 4; k++) expd[exp_n++] = 1'b0;
      end else begin
         comp[comp_n++] = 1'b0;
         comp[comp_n++] = run[1];
         comp[comp_n++] = run[0];
         for (int k = 0; k < run; k++) expd[exp_n++] = 1'b0;
         expd[exp_n++] = 1'b1;
      end
   endtask

   task automatic drive_stream(input bit garble, input bit gaps);
      int  idx = 0;
      bit  v, fire;
      collect = 1'b1;
      while (idx < comp_n) begin
         @(negedge clk);
         v = gaps ? (($urandom % 4) != 0) : 1'b1;
         cmp_valid = v;
         fire = tester_tick && sync && v;
         cmp_bit = (fire || !garble) ? comp[idx] : ~comp[idx];
         @(posedge clk);
         if (fire) idx++;
      end
      @(negedge clk) cmp_valid = 1'b0;
      repeat (16) @(negedge clk);
      collect = 1'b0;
   endtask

   task automatic compare(input string req);
      int first_bad = -1;
      for (int k = 0; k < exp_n && k < got_n; k++)
         if (first_bad < 0 && got[k] != expd[k]) first_bad = k;
      check(got_n == exp_n, req, "scan bit count", got_n, exp_n);
      if (first_bad >= 0)
         check(1'b0, req, $sformatf("scan bit %0d", first_bad),
               int'(got[first_bad]), int'(expd[first_bad]));
      else
         check(1'b1, req, "scan bits", 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int ticks;
      do_reset();
      // R1: reset state
      check(sync == 1'b1 && scan_en == 1'b0, "R1", "sync/scan_en after reset",
            {sync, scan_en}, 2);

      // R7: tick spacing
      ticks = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (tester_tick) ticks++;
      end
      check(ticks == 20 / RATIO, "R7", "tester ticks in 20 cycles", ticks, 20 / RATIO);

      // vector table: R3, R8
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         clear_stream();
         for (int s = 0; s < VEC_CNT[v]; s++) add_sym(int'(VEC_SYMS[v][3*s +: 3]));
         drive_stream(1'b0, 1'b0);
         compare($sformatf("R8 vec%0d", v));
      end

      // R2 / R6 / R4: lone all-zero codeword
      do_reset();
      got_n = 0;
      collect = 1'b1;
      do @(negedge clk); while (!(tester_tick && sync));
      cmp_valid = 1'b1; cmp_bit = 1'b1;
      @(posedge clk);
      @(negedge clk) cmp_valid = 1'b0; cmp_bit = 1'b0;
      check(scan_en && !sync && !scan_data, "R6", "busy state after load",
            {scan_en, sync, scan_data}, 4);
      repeat (8) @(negedge clk);
      collect = 1'b0;
      check(got_n == 4, "R4", "enable cycles for zero group", got_n, 4);
      check(got[0] == 0 && got[1] == 0 && got[2] == 0 && got[3] == 0, "R2",
            "zero group bits", int'({got[0], got[1], got[2], got[3]}), 0);

      // R1: reset in the middle of a codeword
      do_reset();
      do @(negedge clk); while (!(tester_tick && sync));
      cmp_valid = 1'b1; cmp_bit = 1'b0;
      @(posedge clk);
      @(negedge clk) cmp_valid = 1'b0;
      do_reset();
      clear_stream();
      add_sym(4);
      drive_stream(1'b0, 1'b0);
      compare("R1 mid-code reset");

      // R5: input toggling with valid low has no effect
      do_reset();
      got_n = 0; collect = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         cmp_valid = 1'b0; cmp_bit = c[0];
      end
      @(negedge clk) collect = 1'b0;
      check(got_n == 0, "R5", "scan bits with valid low", got_n, 0);

      // R5 / R8: random streams with garbage and gaps
      for (int r = 0; r < 24; r++) begin
         int nsym;
         do_reset();
         clear_stream();
         nsym = 1 + ($urandom % 30);
         for (int s = 0; s < nsym; s++) add_sym(int'($urandom % 5));
         if (r % 2 == 0) add_sym(4);
         drive_stream(r % 3 != 0, r % 2 == 1);
         compare($sformatf("R5 R8 random%0d", r));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule